// File: doc/BRIEF.md
# Flash Write-Protection Gatekeeper

This block sits next to the command sequencer of a serial NOR flash model built from 16 equal sectors. Each sector holds 256 pages of 256 bytes, so a byte address is 20 bits wide. The block holds the protection state of the status byte:

- the status-write lock bit;
- a three-bit protected-region code;
- the write-enable latch;
- the write-in-progress flag.

Each cycle it takes at most one request code from the sequencer. It decides whether a page program, a sector erase, a whole-array erase or a status write may start. When it allows one, the sequencer runs the long internal cycle and reports that through a busy flag.

The protected-region code reserves a top fraction of the sectors, and that fraction doubles with each step of the code. A whole-array erase is only allowed when the code is zero. When the lock bit is set and the write-protect pin is held low, the lock bit and the region code are frozen. Every modifying request needs the write-enable latch to be set first. A request that is allowed, or one that is refused for protection reasons, clears the latch.

The decision comes back as a one-cycle `grant` or `deny` pulse. The status byte is always available for the read path.

Top module: `flash_wprot_check`

## Requirements
- R1: While `rst` is high and in the first cycle after it, `status` is 8'h00 and `grant` and `deny` are 0.
- R2: Request codes are 1 = set write enable, 2 = clear write enable, 3 = page program, 4 = sector erase, 5 = whole-array erase, 6 = status write. Code 1 sets `status[1]` and code 2 clears it.
- R3: A request with code 3, 4, 5 or 6 made while `status[1]` is 0 gives `deny` and changes no status bit.
- R4: The sector is `req_addr[19:16]`. With region code c, the protected sectors are: none for c=0; sector 15 for c=1; sectors 14 and 15 for c=2; sectors 12 to 15 for c=3; sectors 8 to 15 for c=4; all 16 sectors for c=5, 6 and 7.
- R5: A page program or sector erase to a protected sector gives `deny`, clears `status[1]`, and leaves `status[0]` at 0.
- R6: A whole-array erase with write enable set is granted only when the region code is 000. Otherwise it gives `deny` and clears `status[1]`.
- R7: When `status[7]` is 1 and `wp_n` is 0, a status write gives `deny`, clears `status[1]`, and leaves `status[7:2]` unchanged. With `wp_n` high the same write is granted.
- R8: A granted request gives `grant` and clears `status[1]`. `status[0]` then reads 1 from the same cycle on, until the first cycle after `seq_busy` has been sampled high and then low.
- R9: While `status[0]` is 1, every request is ignored: no `grant`, no `deny`, no status change.
- R10: The status byte is {lock, 0, 0, region[2:0], write-enable, in-progress}, so bits 7, 4..2, 1 and 0 carry those fields. A granted status write loads `req_data[7]` into the lock bit and `req_data[4:2]` into the region code, and ignores the other data bits.
- R11: `grant` and `deny` are registered. Each appears exactly one cycle after the request, and the two are never high together.
- R12: Request codes 0 and 7 have no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_op | input | 3 | Request code (0 = none) |
| req_addr | input | 20 | Byte address of program or sector erase |
| req_data | input | 8 | New status byte for a status write |
| wp_n | input | 1 | Write-protect pin, active low |
| seq_busy | input | 1 | Sequencer is running an internal cycle |
| grant | output | 1 | Request allowed, one-cycle pulse |
| deny | output | 1 | Request refused, one-cycle pulse |
| status | output | 8 | Status byte for reads |

## Verification
A sector erase is tried against all 16 sectors under each of the eight region codes. This tells apart every boundary of the doubling region map, and in particular shows that codes 5 to 7 saturate rather than wrap.

Status writes are tried with the lock bit set under both pin levels, which separates the hardware-frozen case from the merely software-locked one. An all-ones data byte shows that only the stored fields are taken.

Requests without write enable, and requests made during a busy cycle, tell apart a refusal from a silent ignore. Unused codes show that they leave the state alone. A behavioural model compares `grant`, `deny` and `status` on every clock.

// File: rtl/flashprot_pkg.sv
package flashprot_pkg;
  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_WEN     = 3'd1,
    OP_WDIS    = 3'd2,
    OP_PROG    = 3'd3,
    OP_SERASE  = 3'd4,
    OP_BERASE  = 3'd5,
    OP_SRWRITE = 3'd6,
    OP_RSVD    = 3'd7
  } fp_op_e;

  localparam int unsigned SR_W     = 8;
  localparam int unsigned SR_WIP   = 0;
  localparam int unsigned SR_WEL   = 1;
  localparam int unsigned SR_BP_LO = 2;
  localparam int unsigned SR_LOCK  = 7;
endpackage

// File: rtl/fp_region_map.sv
module fp_region_map #(
  parameter int unsigned SECTOR_W = 4,
  parameter int unsigned BP_W     = 3
) (
  input  logic [BP_W-1:0]     bp,
  input  logic [SECTOR_W-1:0] sector,
  output logic                locked
);
  localparam logic [SECTOR_W:0] FULL = {1'b1, {SECTOR_W{1'b0}}};

  logic [SECTOR_W:0] span;

  // protected sector count doubles per code step, saturating at the whole array
  always_comb begin
    if (bp == '0)
      span = '0;
    else if (int'(bp) > int'(SECTOR_W))
      span = FULL;
    else
      span = FULL >> (int'(SECTOR_W) + 1 - int'(bp));
    locked = (span != '0) && ({1'b0, sector} >= (FULL - span));
  end

  always_comb begin
    if (bp != '0 && sector == {SECTOR_W{1'b1}})
      AST_TOP_SECTOR_LOCKED: assert (locked); // R4
    if (bp == '0)
      AST_CODE_ZERO_OPEN: assert (!locked); // R4
  end
endmodule

// File: rtl/fp_status_regs.sv
module fp_status_regs
  import flashprot_pkg::*;
#(
  parameter int unsigned BP_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wel_set,
  input  logic            wel_clr,
  input  logic            sr_load,
  input  logic            sr_lock_d,
  input  logic [BP_W-1:0] sr_bp_d,
  input  logic            pend_set,
  input  logic            seq_busy,
  output logic            lock_q,
  output logic [BP_W-1:0] bp_q,
  output logic            wel_q,
  output logic            wip_q,
  output logic [SR_W-1:0] status_q
);
  logic pend_q;
  logic pend_n;

  always_comb pend_n = pend_set | (pend_q & ~seq_busy);

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= 1'b0;
      bp_q   <= '0;
      wel_q  <= 1'b0;
      pend_q <= 1'b0;
      wip_q  <= 1'b0;
    end else begin
      if (sr_load) begin
        lock_q <= sr_lock_d;
        bp_q   <= sr_bp_d;
      end
      if (wel_clr)
        wel_q <= 1'b0;
      else if (wel_set)
        wel_q <= 1'b1;
      pend_q <= pend_n;
      wip_q  <= pend_n | seq_busy;
    end
  end

  always_comb begin
    status_q                   = '0;
    status_q[SR_WIP]           = wip_q;
    status_q[SR_WEL]           = wel_q;
    status_q[SR_BP_LO +: BP_W] = bp_q;
    status_q[SR_LOCK]          = lock_q;
  end

  AST_LOAD_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    sr_load |=> wip_q); // R8
endmodule

// File: rtl/flash_wprot_check.sv
module flash_wprot_check
  import flashprot_pkg::*;
#(
  parameter int unsigned ADDR_W   = 20,
  parameter int unsigned SECTOR_W = 4,
  parameter int unsigned BP_W     = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        req_op,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              wp_n,
  input  logic              seq_busy,
  output logic              grant,
  output logic              deny,
  output logic [7:0]        status
);
  fp_op_e              op;
  logic [SECTOR_W-1:0] sector;
  logic                locked;
  logic                lock_q, wel_q, wip_q;
  logic [BP_W-1:0]     bp_q;
  logic                wel_set, wel_clr, sr_load, pend_set;
  logic                gr_n, dn_n;
  logic                hw_frozen;

  always_comb begin
    op        = fp_op_e'(req_op);
    sector    = req_addr[ADDR_W-1 -: SECTOR_W];
    hw_frozen = lock_q & ~wp_n;
  end

  fp_region_map #(.SECTOR_W(SECTOR_W), .BP_W(BP_W)) u_map (
    .bp(bp_q), .sector(sector), .locked(locked)
  );

  always_comb begin
    wel_set  = 1'b0;
    wel_clr  = 1'b0;
    sr_load  = 1'b0;
    pend_set = 1'b0;
    gr_n     = 1'b0;
    dn_n     = 1'b0;
    if (!wip_q) begin
      case (op)
        OP_WEN:  wel_set = 1'b1;
        OP_WDIS: wel_clr = 1'b1;
        OP_PROG, OP_SERASE: begin
          if (!wel_q) dn_n = 1'b1;
          else if (locked) begin dn_n = 1'b1; wel_clr = 1'b1; end
          else begin gr_n = 1'b1; wel_clr = 1'b1; pend_set = 1'b1; end
        end
        OP_BERASE: begin
          if (!wel_q) dn_n = 1'b1;
          else if (bp_q != '0) begin dn_n = 1'b1; wel_clr = 1'b1; end
          else begin gr_n = 1'b1; wel_clr = 1'b1; pend_set = 1'b1; end
        end
        OP_SRWRITE: begin
          if (!wel_q) dn_n = 1'b1;
          else if (hw_frozen) begin dn_n = 1'b1; wel_clr = 1'b1; end
          else begin
            gr_n = 1'b1; wel_clr = 1'b1; pend_set = 1'b1; sr_load = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  fp_status_regs #(.BP_W(BP_W)) u_regs (
    .clk(clk), .rst(rst),
    .wel_set(wel_set), .wel_clr(wel_clr),
    .sr_load(sr_load), .sr_lock_d(req_data[SR_LOCK]),
    .sr_bp_d(req_data[SR_BP_LO +: BP_W]),
    .pend_set(pend_set), .seq_busy(seq_busy),
    .lock_q(lock_q), .bp_q(bp_q), .wel_q(wel_q), .wip_q(wip_q),
    .status_q(status)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      grant <= 1'b0;
      deny  <= 1'b0;
    end else begin
      grant <= gr_n;
      deny  <= dn_n;
    end
  end

  AST_GRANT_DENY_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(grant && deny)); // R11
  AST_GRANT_SETS_WIP: assert property (@(posedge clk) disable iff (rst)
    grant |-> (status[SR_WIP] && !status[SR_WEL])); // R8
  AST_NO_WEL_DENY: assert property (@(posedge clk) disable iff (rst)
    (!wip_q && !wel_q && (op == OP_PROG || op == OP_SERASE ||
      op == OP_BERASE || op == OP_SRWRITE)) |=> (deny && !grant)); // R3
  AST_BULK_GUARD: assert property (@(posedge clk) disable iff (rst)
    (op == OP_BERASE && bp_q != '0) |=> !grant); // R6
  AST_HPM_FREEZE: assert property (@(posedge clk) disable iff (rst)
    (lock_q && !wp_n && op == OP_SRWRITE) |=> $stable(status[7:2])); // R7
  AST_BUSY_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (wip_q && op != OP_IDLE) |=> (!grant && !deny)); // R9
endmodule

// File: tb/sim_flash_wprot_check.sv
`timescale 1ns/1ps
module sim_flash_wprot_check;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [2:0] req_op = 3'd0;
  logic [19:0] req_addr = '0;
  logic [7:0] req_data = '0;
  logic wp_n = 1'b1;
  logic seq_busy = 1'b0;
  logic grant, deny;
  logic [7:0] status;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string tag = "R11";
  logic last_g, last_d;

  // reference state
  bit m_lock, m_wel, m_pend, m_wip, m_g, m_d;
  int m_bp;

  always #2 clk = ~clk;

  flash_wprot_check u0 (
    .clk(clk), .rst(rst), .req_op(req_op), .req_addr(req_addr),
    .req_data(req_data), .wp_n(wp_n), .seq_busy(seq_busy),
    .grant(grant), .deny(deny), .status(status)
  );

  function automatic bit sect_locked(int bp, int s);
    case (bp)
      0: return 0;
      1: return s == 15;
      2: return s >= 14;
      3: return s >= 12;
      4: return s >= 8;
      default: return 1;
    endcase
  endfunction

  function automatic logic [7:0] m_status();
    logic [7:0] v;
    v = 8'h00;
    v[7] = m_lock;
    v[4:2] = m_bp[2:0];
    v[1] = m_wel;
    v[0] = m_wip;
    return v;
  endfunction

  task automatic check(string t, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h at %0t", t, act, exp, $time);
    end
  endtask

  // cycle-by-cycle model and comparison
  always @(posedge clk) begin
    cyc++;
    m_g = 0; m_d = 0;
    if (rst) begin
      m_lock = 0; m_bp = 0; m_wel = 0; m_pend = 0; m_wip = 0;
    end else begin
      if (!m_wip) begin
        case (req_op)
          3'd1: m_wel = 1;
          3'd2: m_wel = 0;
          3'd3, 3'd4: begin
            if (!m_wel) m_d = 1;
            else if (sect_locked(m_bp, int'(req_addr[19:16]))) begin m_d = 1; m_wel = 0; end
            else begin m_g = 1; m_wel = 0; end
          end
          3'd5: begin
            if (!m_wel) m_d = 1;
            else if (m_bp != 0) begin m_d = 1; m_wel = 0; end
            else begin m_g = 1; m_wel = 0; end
          end
          3'd6: begin
            if (!m_wel) m_d = 1;
            else if (m_lock && !wp_n) begin m_d = 1; m_wel = 0; end
            else begin
              m_g = 1; m_wel = 0; m_lock = req_data[7]; m_bp = int'(req_data[4:2]);
            end
          end
          default: ;
        endcase
      end
      if (m_g) m_pend = 1;
      else if (seq_busy) m_pend = 0;
      m_wip = m_pend | seq_busy;
    end
    #1;
    check({tag, " grant"}, {7'd0, grant}, {7'd0, m_g});
    check({tag, " deny"}, {7'd0, deny}, {7'd0, m_d});
    check({tag, " status"}, status, m_status());
  end

  task automatic issue(input logic [2:0] op, input logic [19:0] addr, input logic [7:0] data);
    @(negedge clk);
    req_op = op; req_addr = addr; req_data = data;
    @(negedge clk);
    req_op = 3'd0;
    last_g = grant;
    last_d = deny;
  endtask

  task automatic busy_pulse();
    @(negedge clk) seq_busy = 1'b1;
    repeat (2) @(negedge clk);
    seq_busy = 1'b0;
    @(negedge clk);
  endtask

  task automatic set_sr(input logic [7:0] d);
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd6, 20'h0, d);
    busy_pulse();
  endtask

  initial begin
    tag = "R1";
    repeat (3) @(negedge clk);
    check("R1 reset status", status, 8'h00);
    check("R1 reset grant/deny", {6'd0, grant, deny}, 8'h00);
    rst = 1'b0;
    @(negedge clk);
    check("R1 post-reset status", status, 8'h00);

    tag = "R3";
    issue(3'd3, 20'h12345, 8'h00);
    check("R3 program without enable denied", {6'd0, last_g, last_d}, 8'h01);
    check("R3 status unchanged", status, 8'h00);

    tag = "R2";
    issue(3'd1, 20'h0, 8'h00);
    check("R2 enable sets bit1", status, 8'h02);
    issue(3'd2, 20'h0, 8'h00);
    check("R2 disable clears bit1", status, 8'h00);

    tag = "R12";
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd7, 20'hF0000, 8'hFF);
    check("R12 code 7 no effect", status, 8'h02);
    issue(3'd0, 20'hF0000, 8'hFF);
    check("R12 code 0 no effect", {last_g, last_d, status[5:0]}, 8'h02);

    tag = "R8";
    issue(3'd3, 20'hF0010, 8'h00);
    check("R8 program granted", {6'd0, last_g, last_d}, 8'h02);
    check("R8 wip set, enable cleared", status, 8'h01);
    tag = "R9";
    issue(3'd1, 20'h0, 8'h00);
    check("R9 request ignored while busy", {6'd0, last_g, last_d}, 8'h00);
    check("R9 status unchanged while busy", status, 8'h01);
    issue(3'd6, 20'h0, 8'hFC);
    check("R9 status write ignored", status, 8'h01);
    tag = "R8";
    busy_pulse();
    check("R8 wip clears after busy", status, 8'h00);

    tag = "R4";
    for (int c = 0; c < 8; c++) begin
      set_sr(8'(c << 2));
      check("R4 region code loaded", status, 8'(c << 2));
      for (int s = 0; s < 16; s++) begin
        issue(3'd1, 20'h0, 8'h00);
        issue(3'd4, {s[3:0], 16'h00A5}, 8'h00);
        check("R4 sector erase decision", {6'd0, last_g, last_d},
              sect_locked(c, s) ? 8'h01 : 8'h02);
        if (last_g) busy_pulse();
        else check("R5 protected denial clears enable, no wip", status[1:0], 2'b00);
      end
    end

    tag = "R5";
    set_sr(8'h04);
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd3, 20'hF1234, 8'h00);
    check("R5 program to sector 15 denied", {6'd0, last_g, last_d}, 8'h01);
    check("R5 status after denial", status, 8'h04);

    tag = "R6";
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd5, 20'h0, 8'h00);
    check("R6 bulk erase with region set denied", {6'd0, last_g, last_d}, 8'h01);
    check("R6 enable cleared", status, 8'h04);
    set_sr(8'h00);
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd5, 20'h0, 8'h00);
    check("R6 bulk erase with code 000 granted", {6'd0, last_g, last_d}, 8'h02);
    busy_pulse();

    tag = "R7";
    set_sr(8'h88);
    check("R7 lock and region loaded", status, 8'h88);
    wp_n = 1'b0;
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd6, 20'h0, 8'h00);
    check("R7 frozen status write denied", {6'd0, last_g, last_d}, 8'h01);
    check("R7 status kept", status, 8'h88);
    @(negedge clk) wp_n = 1'b1;
    issue(3'd1, 20'h0, 8'h00);
    issue(3'd6, 20'h0, 8'h00);
    check("R7 pin high allows write", {6'd0, last_g, last_d}, 8'h02);
    busy_pulse();
    check("R7 status cleared", status, 8'h00);

    tag = "R10";
    set_sr(8'hFF);
    check("R10 only stored fields taken", status, 8'h9C);
    set_sr(8'h63);
    check("R10 ignored data bits", status, 8'h00);

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  always @(negedge clk) begin
    if (cyc > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule